// File: doc/BRIEF.md
# Multi-type 1-D transform engine

This block is the one-dimensional integer transform stage of a video encoder's residual path. Each pass takes a packed group of signed residual samples, 32 lanes wide. It also takes a transform length, a kernel choice and a rounding shift. It returns the matching transform coefficients, packed in the same layout. Three kernels share one multiply-accumulate datapath: a cosine kernel (DCT2) and two sine-derived kernels (DST7, DCT8).

A 32-point line fills the whole width. Shorter lines are packed side by side, so one pass transforms 32/N independent lines of length N. The engine spends N cycles per pass and computes coefficient k of every packed line in cycle k. Two instances, one for rows and one for columns, make up a 2-D transform. Both edges use valid/ready handshakes. Output backpressure holds the finished group and stops new work without losing data.

Top module: `mt_xform1d`

## Requirements
- R1: `in_lgsize` = L selects N = 2^L points (L from 1 to 5). Line g uses input lanes g*N to g*N+N-1, with sample n in lane g*N+n. Coefficient k of line g appears in output lane g*N+k. Lane i sits in bits [16i+15:16i] of the data buses.
- R2: Kind code 0 (DCT2) uses the basis value round(64*cos(pi*(2n+1)*k/(2N))) for coefficient k and sample n.
- R3: Kind code 1 (DST7) uses the basis value round(64*sin(pi*(2n+1)*(k+1)/(2N+1))).
- R4: Kind code 2 (DCT8) uses the basis value (-1)^k times the DST7 value of the same k at sample N-1-n.
- R5: Each coefficient is the exact sum of sample-times-basis products, shifted arithmetically right by s = `in_shift` (0 to 15). When s > 0, 2^(s-1) is added before the shift.
- R6: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R7: Three kinds of combination are illegal: L of 0, 6 or 7; kind code 3; and kind 1 or 2 with L = 1. Such a request is still accepted by the handshake. It raises `err` for exactly the one cycle after acceptance and produces no output group.
- R8: With the output free, `out_valid` rises on the Nth rising edge after the edge that accepted the group.
- R9: When the output is not blocked, back-to-back groups are accepted every N cycles.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Every accepted legal group is delivered once, in order.
- R11: After reset, `out_valid` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Engine can take a group this cycle |
| in_lgsize | input | 3 | log2 of the transform length |
| in_kind | input | 2 | Kernel: 0 DCT2, 1 DST7, 2 DCT8 |
| in_shift | input | 4 | Rounding right shift |
| in_data | input | 512 | 32 packed signed 16-bit samples |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Consumer takes the output group |
| out_data | output | 512 | 32 packed signed 16-bit coefficients |
| err | output | 1 | One-cycle flag for an illegal request |

## Verification
A group accepted on rising edge A is due on `out_valid` from edge A+N when the output is free. The bench notes the cycle counter at the falling edge before each accepting edge. It checks the first falling edge at which the group is visible against that count plus N. It makes this check only in phases where `out_ready` is held high. `err` is due one edge after acceptance and is sampled at the next falling edge. Successive acceptances are compared to an N-cycle spacing, and stalled outputs are compared across consecutive falling edges.

// File: rtl/mt_xform1d.sv
module mt_xform1d #(
  parameter int SW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_lgsize,
  input  logic [1:0]           in_kind,
  input  logic [3:0]           in_shift,
  input  logic [32*SW-1:0]     in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [32*SW-1:0]     out_data,
  output logic                 err
);
  localparam int LANES = 32;
  localparam int ROMN  = 376;
  localparam int TW    = AW + 2;
  localparam real PI   = 3.141592653589793;
  localparam logic signed [TW-1:0] MAXV = TW'((2 ** (SW - 1)) - 1);
  localparam logic signed [TW-1:0] MINV = -TW'(2 ** (SW - 1));

  function automatic int rom_val(int e);
    if (e < 128) return int'(64.0 * $cos(PI * e / 64.0));
    if (e < 146) return int'(64.0 * $sin(PI * (e - 128) / 9.0));
    if (e < 180) return int'(64.0 * $sin(PI * (e - 146) / 17.0));
    if (e < 246) return int'(64.0 * $sin(PI * (e - 180) / 33.0));
    return int'(64.0 * $sin(PI * (e - 246) / 65.0));
  endfunction

  function automatic logic [8:0] stepf(logic [1:0] kind, logic [2:0] lg, int i);
    int l, n, m;
    l = int'(lg);
    n = i & ((1 << l) - 1);
    m = (kind == 2'd2) ? ((1 << l) - 1 - n) : n;
    return (kind == 2'd0) ? 9'((2 * m + 1) << (5 - l)) : 9'(2 * m + 1);
  endfunction

  logic              busy, last, out_free, acc, legal, take;
  logic [4:0]        kcnt;
  logic [5:0]        npts;
  logic [2:0]        lg_r;
  logic [1:0]        kind_r;
  logic [3:0]        sh_r;
  logic [8:0]        per, rbase;
  logic signed [SW-1:0] x_r   [LANES];
  logic signed [SW-1:0] cbuf  [LANES];
  logic signed [SW-1:0] cnext [LANES];
  logic [8:0]        ph      [LANES];
  logic [8:0]        ph_adv  [LANES];
  logic [8:0]        ph_init [LANES];
  logic signed [7:0] coef    [LANES];
  logic signed [7:0] rom     [ROMN];
  logic signed [AW-1:0] lv   [6][LANES];

  for (genvar e = 0; e < ROMN; e++) begin : g_rom
    localparam logic signed [7:0] RV = 8'(rom_val(e));
    assign rom[e] = RV;
  end

  assign npts     = 6'd1 << lg_r;
  assign out_free = !out_valid || out_ready;
  assign last     = busy && ({1'b0, kcnt} == npts - 6'd1);
  assign in_ready = !busy || (last && out_free);
  assign acc      = in_valid && in_ready;
  assign legal    = (in_lgsize >= 3'd1) && (in_lgsize <= 3'd5) &&
                    ((in_kind == 2'd0) || ((in_kind != 2'd3) && (in_lgsize >= 3'd2)));
  assign take     = acc && legal;

  always_comb begin
    per = (kind_r == 2'd0) ? 9'd128 : 9'((4 << lg_r) + 2);
    case (lg_r)
      3'd2:    rbase = 9'd128;
      3'd3:    rbase = 9'd146;
      3'd4:    rbase = 9'd180;
      default: rbase = 9'd246;
    endcase
    if (kind_r == 2'd0) rbase = 9'd0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] step, sum9;
    logic signed [7:0] c;
    always_comb begin
      step       = stepf(kind_r, lg_r, i);
      sum9       = ph[i] + step;
      ph_adv[i]  = (sum9 >= per) ? sum9 - per : sum9;
      ph_init[i] = (in_kind == 2'd0) ? 9'd0 : stepf(in_kind, in_lgsize, i);
      c          = rom[rbase + ph[i]];
      coef[i]    = (kind_r == 2'd2 && kcnt[0]) ? -c : c;
    end
    assign lv[0][i] = AW'(x_r[i]) * AW'(coef[i]);

    assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ph[i] < per);
  end

  for (genvar L = 1; L <= 5; L++) begin : g_lvl
    for (genvar g = 0; g < LANES; g++) begin : g_node
      if (g < (LANES >> L)) begin : g_sum
        assign lv[L][g] = lv[L-1][2*g] + lv[L-1][2*g+1];
      end else begin : g_nil
        assign lv[L][g] = '0;
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic signed [AW-1:0] gs;
    logic signed [TW-1:0] off, t, r;
    logic signed [SW-1:0] rs;
    always_comb begin
      gs  = lv[lg_r][j >> lg_r];
      off = (sh_r == 4'd0) ? '0 : (TW'(1) << (sh_r - 4'd1));
      t   = TW'(gs) + off;
      r   = t >>> sh_r;
      rs  = (r > MAXV) ? SW'(MAXV) : (r < MINV) ? SW'(MINV) : SW'(r);
      cnext[j] = ((5'(j) & 5'(npts - 6'd1)) == kcnt) ? rs : cbuf[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kcnt      <= '0;
      out_valid <= 1'b0;
      err       <= 1'b0;
      lg_r      <= 3'd1;
      kind_r    <= '0;
      sh_r      <= '0;
      out_data  <= '0;
      for (int i = 0; i < LANES; i++) begin
        x_r[i]  <= '0;
        cbuf[i] <= '0;
        ph[i]   <= '0;
      end
    end else begin
      err <= acc && !legal;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (busy) begin
        if (!last) begin
          kcnt <= kcnt + 5'd1;
          for (int i = 0; i < LANES; i++) begin
            cbuf[i] <= cnext[i];
            ph[i]   <= ph_adv[i];
          end
        end else if (out_free) begin
          for (int i = 0; i < LANES; i++) out_data[i*SW +: SW] <= cnext[i];
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end
      end
      if (take) begin
        busy   <= 1'b1;
        kcnt   <= '0;
        lg_r   <= in_lgsize;
        kind_r <= in_kind;
        sh_r   <= in_shift;
        for (int i = 0; i < LANES; i++) begin
          x_r[i] <= in_data[i*SW +: SW];
          ph[i]  <= ph_init[i];
        end
      end
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_err_from_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready));
  assert_err_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$rose(busy));
  assert_out_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
endmodule

// File: tb/sim_mt_xform1d.sv
module sim_mt_xform1d;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, err;
  logic [2:0] in_lgsize = '0;
  logic [1:0] in_kind = '0;
  logic [3:0] in_shift = '0;
  logic [511:0] in_data = '0, out_data;

  mt_xform1d u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lgsize(in_lgsize), .in_kind(in_kind), .in_shift(in_shift), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err(err));

  always #2 clk = ~clk;

  typedef struct { logic [511:0] d; int due; bit strict; string req; } item_t;
  item_t q[$];
  int total = 0, fails = 0, cyc = 0, rmode = 0;
  bit running = 0, seen = 0, stall_prev = 0;
  int first_seen = 0;
  logic [511:0] held;
  logic signed [15:0] xs [32];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    out_ready = (rmode == 0) ? 1'b1 : (cyc % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bas(int kind, int lg, int k, int n);
    int nn, m;
    real v;
    nn = 1 << lg;
    if (kind == 0) v = 64.0 * $cos(PI * (2 * n + 1) * k / (2.0 * nn));
    else begin
      m = (kind == 2) ? nn - 1 - n : n;
      v = 64.0 * $sin(PI * (2 * m + 1) * (k + 1) / (2.0 * nn + 1.0));
      if (kind == 2 && (k % 2) == 1) v = -v;
    end
    return int'(v);
  endfunction

  function automatic logic [511:0] refcalc(int lg, int kind, int sh);
    logic [511:0] r;
    longint s;
    int nn;
    nn = 1 << lg;
    for (int g = 0; g < 32 / nn; g++)
      for (int k = 0; k < nn; k++) begin
        s = 0;
        for (int n = 0; n < nn; n++) s += longint'(xs[g*nn+n]) * bas(kind, lg, k, n);
        if (sh > 0) s = (s + (longint'(1) << (sh - 1))) >>> sh;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[(g*nn+k)*16 +: 16] = 16'(s);
      end
    return r;
  endfunction

  task automatic send(input int lg, input int kind, input int sh, input bit strict,
                      input string req, output int acc);
    item_t it;
    bit ok;
    ok = (lg >= 1 && lg <= 5) && (kind == 0 || ((kind == 1 || kind == 2) && lg >= 2));
    @(negedge clk);
    in_valid = 1'b1; in_lgsize = 3'(lg); in_kind = 2'(kind); in_shift = 4'(sh);
    for (int i = 0; i < 32; i++) in_data[i*16 +: 16] = xs[i];
    while (!in_ready) @(negedge clk);
    acc = cyc + 1;
    if (ok) begin
      it.d = refcalc(lg, kind, sh); it.due = acc + (1 << lg);
      it.strict = strict; it.req = req;
      q.push_back(it);
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fill(input int mode, input int amp);
    for (int i = 0; i < 32; i++)
      case (mode)
        0: xs[i] = 16'($signed($urandom % (2 * amp + 1)) - amp);
        1: xs[i] = 16'(amp);
        default: xs[i] = '0;
      endcase
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "groups left undelivered", q.size(), 0);
  endtask

  always @(negedge clk) if (running) begin
    item_t it;
    if (stall_prev) begin
      chk(out_valid == 1'b1, "R10", "valid dropped under stall", out_valid, 1);
      chk(out_data == held, "R10", "data changed under stall", out_data[15:0], held[15:0]);
    end
    if (out_valid && !seen) begin seen = 1; first_seen = cyc; end
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(0, "R7", "unexpected output group", 1, 0);
      else begin
        it = q.pop_front();
        for (int j = 0; j < 32; j++)
          if (out_data[j*16 +: 16] !== it.d[j*16 +: 16]) begin
            chk(0, it.req, $sformatf("lane %0d", j), longint'($signed(out_data[j*16 +: 16])),
                longint'($signed(it.d[j*16 +: 16])));
            break;
          end
        chk(1, it.req, "group", 0, 0);
        if (it.strict) chk(first_seen == it.due, "R8", "output cycle", first_seen, it.due);
      end
      seen = 0;
    end
    stall_prev = out_valid && !out_ready;
    held = out_data;
  end

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R11", "in_ready after reset", in_ready, 1);
    chk(err == 0, "R11", "err after reset", err, 0);
    chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
    running = 1;

    fill(0, 2047); send(5, 0, 6, 1, "R2", a); idle(); drain();
    fill(0, 2047); send(1, 0, 1, 1, "R1", a); idle(); drain();
    fill(0, 1000); send(4, 1, 7, 1, "R3", a); idle(); drain();
    fill(0, 500);  send(2, 1, 4, 1, "R3", a); idle(); drain();
    fill(0, 2047); send(3, 2, 5, 1, "R4", a); idle(); drain();
    fill(0, 2047); send(5, 2, 8, 1, "R4", a); idle(); drain();

    fill(2, 0); xs[8] = 16'sd1; send(3, 0, 0, 1, "R1", a); idle(); drain();
    fill(2, 0); xs[0] = 16'sd1; send(1, 0, 1, 1, "R5", a); idle(); drain();
    fill(2, 0); xs[0] = -16'sd1; xs[3] = 16'sd1; send(1, 0, 1, 1, "R5", a); idle(); drain();
    fill(0, 30000); send(4, 1, 15, 1, "R5", a); idle(); drain();
    fill(1, 32767); send(5, 0, 0, 1, "R6", a); idle(); drain();
    fill(1, -32768); send(5, 0, 0, 1, "R6", a); idle(); drain();

    fill(0, 100);
    send(1, 1, 0, 0, "R7", a); idle(); chk(err == 1, "R7", "err for kind 1 at L=1", err, 1);
    @(negedge clk); chk(err == 0, "R7", "err length", err, 0);
    send(3, 3, 0, 0, "R7", a); idle(); chk(err == 1, "R7", "err for kind 3", err, 1);
    send(0, 0, 0, 0, "R7", a); idle(); chk(err == 1, "R7", "err for L=0", err, 1);
    send(6, 0, 0, 0, "R7", a); idle(); chk(err == 1, "R7", "err for L=6", err, 1);
    send(7, 2, 0, 0, "R7", a); idle(); chk(err == 1, "R7", "err for L=7", err, 1);
    repeat (40) @(negedge clk);
    chk(out_valid == 0, "R7", "no output after illegal", out_valid, 0);

    fill(0, 2047); send(3, 0, 3, 1, "R9", b);
    for (int i = 0; i < 3; i++) begin
      fill(0, 2047); send(3, i % 3, 3, 1, "R9", a);
      chk(a - b == 8, "R9", "acceptance spacing", a - b, 8);
      b = a;
    end
    idle(); drain();

    rmode = 1;
    for (int i = 0; i < 6; i++) begin
      fill(0, 1500); send(1 + (i % 5), (i % 2 == 0) ? 0 : 1 + (i % 3 == 0), 5, 0, "R10", a);
    end
    idle(); drain();
    rmode = 0;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule